// File: doc/BRIEF.md
# Host Control Register Bank with Pin Merging

This block holds the host-visible configuration and status bytes of a video input processor. A write table of configuration bytes sets the datapath features. A read table of status bytes is sampled from the datapath on every clock. The host reaches both tables through an 8-bit parallel port. On that port, one byte lane carries an address in one phase and data in the next. The port is qualified by an active-low chip select, a read/write line and an address/data select. A mode input hands the host path to a serial engine that lies outside this block. While that input is high, the parallel port is inert.

Seven control bits in the control byte (location 0) each have a matching external pin. A fixed rule per bit combines the bit with its pin to give the enable the datapath sees. A bit that resets to 0 is ORed with its pin. The two blanking-related bits reset to 1 and are ANDed with their pins. The ancillary checksum bit resets to 1 but is ORed with its pin, so its pin has effect only after the host clears the bit. One global pin also forces the clipping, timing-reference blanking and timing-reference insertion enables on, and the host cannot override it.

The rest of the chip uses this block as the single point where register state and strap pins become effective enables.

Top module: `hreg_bank`

## Requirements
- R1: After synchronous reset, location 0 of the write table reads 0x70 (bits 4, 5 and 6 set), all other write locations read 0x00, and bus_oe is low.
- R2: A cycle with host_cs_n low and host_ad low captures bus_in as the address. A later cycle with host_cs_n low, host_ad high and host_rw low writes bus_in into that write location. The new value appears on cfg_out (byte n at bits 8n+7..8n) one cycle later.
- R3: A cycle with host_cs_n low, host_ad high and host_rw high makes bus_oe high and bus_out equal to the status byte at the latched address on the next cycle. The status byte n is taken from stat_in bits 8n+7..8n as sampled one clock before that read cycle.
- R4: A read of an address of 23 or above returns 0x00. A write to an address of 15 or above changes no byte of cfg_out.
- R5: bus_oe is low in the cycle after any cycle in which host_cs_n is high.
- R6: While host_mode is high, the parallel port neither latches an address nor writes a location, and bus_oe stays low.
- R7: Control bits 0 (clipping), 1 (timing-reference blanking), 2 (timing-reference insertion) and 3 (ancillary header remap) reset to 0, and each ctrl_en[i] is the OR of control bit i and ctrl_pin[i].
- R8: Control bits 5 (vertical blanking select) and 6 (blank enable) reset to 1, and each ctrl_en[i] is the AND of control bit i and ctrl_pin[i].
- R9: Control bit 4 (ancillary checksum) resets to 1, and ctrl_en[4] is the OR of the bit and ctrl_pin[4]. ctrl_pin[4] therefore changes nothing until the host writes the bit to 0.
- R10: While clip_trs_pin is high, ctrl_en[0], ctrl_en[1] and ctrl_en[2] are all 1, whatever the control byte holds.
- R11: ctrl_en is registered. It reflects a pin change or a table write one clock after the change reaches the merge logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | High selects the serial host path; the parallel port is disabled |
| host_cs_n | input | 1 | Parallel port chip select, active low |
| host_rw | input | 1 | High for a read data phase, low for a write data phase |
| host_ad | input | 1 | Low marks an address phase, high marks a data phase |
| bus_in | input | 8 | Byte lane into the block, carrying address or data |
| bus_out | output | 8 | Read data driven toward the host |
| bus_oe | output | 1 | Output enable for bus_out; low means the lane floats |
| ctrl_pin | input | 7 | External pins paired with control bits 0 to 6 |
| clip_trs_pin | input | 1 | Global pin that forces enables 0, 1 and 2 on |
| stat_in | input | 184 | Status bytes from the datapath, byte n at bits 8n+7..8n |
| cfg_out | output | 120 | Full write table, byte n at bits 8n+7..8n |
| ctrl_en | output | 7 | Effective enables after pin merging |

## Verification
The bench targets the checksum bit. It checks that ctrl_pin[4] has no effect while the bit holds its reset value of 1 and takes over once the bit is cleared. A design that applied the default-1 AND rule to this bit would lose the enable when the pin is low. A second target is the blanking pair: a design that ORed instead of ANDed them could not be disabled by a low pin. The global clip pin is driven high while the host writes zeros to the control byte; a merge that let the host win would drop the three forced enables. Out-of-range reads and writes, and activity while host_mode is high, are also exercised. A decoder that wrapped addresses would corrupt a real location, and an ungated port would take writes meant for the serial path.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int CTRL_N = 7;
  // Reset value of the control bits held in the control byte.
  localparam logic [CTRL_N-1:0] CTRL_RESET = 7'b1110000;
  // Bits combined with their pin by AND; all other bits use OR.
  localparam logic [CTRL_N-1:0] CTRL_AND   = 7'b1100000;
  // Bits forced on by the global clip pin.
  localparam logic [CTRL_N-1:0] CTRL_FORCE = 7'b0000111;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WRITE, PH_READ} phase_t;
endpackage

// File: rtl/hreg_port.sv
module hreg_port
  import hreg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_mode,
  input  logic          host_cs_n,
  input  logic          host_rw,
  input  logic          host_ad,
  input  logic [DW-1:0] bus_in,
  output phase_t        phase,
  output logic [AW-1:0] lat_addr
);
  logic active;

  assign active = !host_mode && !host_cs_n;

  always_comb begin
    if (!active)      phase = PH_IDLE;
    else if (!host_ad) phase = PH_ADDR;
    else if (host_rw)  phase = PH_READ;
    else               phase = PH_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst)                 lat_addr <= '0;
    else if (phase == PH_ADDR) lat_addr <= AW'(bus_in);
  end
endmodule

// File: rtl/hreg_wtable.sv
module hreg_wtable
  import hreg_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int WR_DEPTH = 15,
  parameter int CTRL_LOC = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic [WR_DEPTH*DW-1:0] table_q
);
  for (genvar g = 0; g < WR_DEPTH; g++) begin : g_loc
    localparam logic [DW-1:0] RST_VAL = (g == CTRL_LOC) ? DW'(CTRL_RESET) : '0;
    logic [DW-1:0] loc_q;

    always_ff @(posedge clk) begin
      if (rst)                                 loc_q <= RST_VAL;
      else if (wr_en && wr_addr == AW'(g))     loc_q <= wr_data;
    end

    assign table_q[g*DW +: DW] = loc_q;
  end
endmodule

// File: rtl/hreg_rtable.sv
module hreg_rtable #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int RD_DEPTH = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RD_DEPTH*DW-1:0] stat_in,
  input  logic                   rd_en,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_oe
);
  logic [RD_DEPTH*DW-1:0] snap_q;
  logic [DW-1:0]          pick;

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else     snap_q <= stat_in;
  end

  // Unimplemented addresses fall through with zero.
  always_comb begin
    pick = '0;
    for (int i = 0; i < RD_DEPTH; i++)
      if (rd_addr == AW'(i)) pick = snap_q[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_data <= rd_en ? pick : '0;
      rd_oe   <= rd_en;
    end
  end
endmodule

// File: rtl/hreg_merge.sv
module hreg_merge
  import hreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_N-1:0] ctrl_bits,
  input  logic [CTRL_N-1:0] ctrl_pin,
  input  logic              clip_trs_pin,
  output logic [CTRL_N-1:0] ctrl_en
);
  logic [CTRL_N-1:0] comb_en;

  for (genvar i = 0; i < CTRL_N; i++) begin : g_bit
    if (CTRL_AND[i]) begin : g_and
      if (CTRL_FORCE[i]) begin : g_f
        assign comb_en[i] = (ctrl_bits[i] & ctrl_pin[i]) | clip_trs_pin;
      end else begin : g_nf
        assign comb_en[i] = ctrl_bits[i] & ctrl_pin[i];
      end
    end else begin : g_or
      if (CTRL_FORCE[i]) begin : g_f
        assign comb_en[i] = ctrl_bits[i] | ctrl_pin[i] | clip_trs_pin;
      end else begin : g_nf
        assign comb_en[i] = ctrl_bits[i] | ctrl_pin[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_en <= CTRL_RESET & ~CTRL_AND;
    else     ctrl_en <= comb_en;
  end
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
  import hreg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int WR_DEPTH = 15,
  parameter int RD_DEPTH = 23,
  parameter int CTRL_LOC = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_mode,
  input  logic                   host_cs_n,
  input  logic                   host_rw,
  input  logic                   host_ad,
  input  logic [DW-1:0]          bus_in,
  output logic [DW-1:0]          bus_out,
  output logic                   bus_oe,
  input  logic [CTRL_N-1:0]      ctrl_pin,
  input  logic                   clip_trs_pin,
  input  logic [RD_DEPTH*DW-1:0] stat_in,
  output logic [WR_DEPTH*DW-1:0] cfg_out,
  output logic [CTRL_N-1:0]      ctrl_en
);
  phase_t        phase;
  logic [AW-1:0] lat_addr;

  hreg_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .host_mode(host_mode), .host_cs_n(host_cs_n),
    .host_rw(host_rw), .host_ad(host_ad), .bus_in(bus_in),
    .phase(phase), .lat_addr(lat_addr)
  );

  hreg_wtable #(.AW(AW), .DW(DW), .WR_DEPTH(WR_DEPTH), .CTRL_LOC(CTRL_LOC)) u_wtab (
    .clk(clk), .rst(rst), .wr_en(phase == PH_WRITE), .wr_addr(lat_addr),
    .wr_data(bus_in), .table_q(cfg_out)
  );

  hreg_rtable #(.AW(AW), .DW(DW), .RD_DEPTH(RD_DEPTH)) u_rtab (
    .clk(clk), .rst(rst), .stat_in(stat_in), .rd_en(phase == PH_READ),
    .rd_addr(lat_addr), .rd_data(bus_out), .rd_oe(bus_oe)
  );

  hreg_merge u_merge (
    .clk(clk), .rst(rst), .ctrl_bits(cfg_out[CTRL_LOC*DW +: CTRL_N]),
    .ctrl_pin(ctrl_pin), .clip_trs_pin(clip_trs_pin), .ctrl_en(ctrl_en)
  );
endmodule

// File: rtl/hreg_bank_chk.sv
module hreg_bank_chk
  import hreg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int WR_DEPTH = 15,
  parameter int RD_DEPTH = 23
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_mode,
  input logic                   host_cs_n,
  input logic                   host_rw,
  input logic                   host_ad,
  input logic [DW-1:0]          bus_out,
  input logic                   bus_oe,
  input logic [CTRL_N-1:0]      ctrl_pin,
  input logic                   clip_trs_pin,
  input logic [WR_DEPTH*DW-1:0] cfg_out,
  input logic [CTRL_N-1:0]      ctrl_en,
  input logic [AW-1:0]          lat_addr
);
  assert_float_idle_R5: assert property (@(posedge clk) disable iff (rst)
    host_cs_n |=> !bus_oe);

  assert_mode_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> !bus_oe);

  assert_mode_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> $stable(cfg_out));

  assert_oe_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && !host_cs_n && host_ad && host_rw) |=> bus_oe);

  assert_unimpl_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && !host_cs_n && host_ad && host_rw && lat_addr >= AW'(RD_DEPTH))
      |=> (bus_out == '0));

  assert_unimpl_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && !host_cs_n && host_ad && !host_rw && lat_addr >= AW'(WR_DEPTH))
      |=> $stable(cfg_out));

  assert_or_pin_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_pin[3] |=> ctrl_en[3]);

  assert_and_pin_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_pin[5] || !ctrl_pin[6]) |=> !(ctrl_en[5] && ctrl_en[6]));

  assert_cksum_pin_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl_pin[4] |=> ctrl_en[4]);

  assert_global_force_R10: assert property (@(posedge clk) disable iff (rst)
    clip_trs_pin |=> (ctrl_en[2:0] == 3'b111));
endmodule

bind hreg_bank hreg_bank_chk #(
  .DW(DW), .AW(AW), .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .host_mode(host_mode), .host_cs_n(host_cs_n),
  .host_rw(host_rw), .host_ad(host_ad), .bus_out(bus_out), .bus_oe(bus_oe),
  .ctrl_pin(ctrl_pin), .clip_trs_pin(clip_trs_pin), .cfg_out(cfg_out),
  .ctrl_en(ctrl_en), .lat_addr(lat_addr)
);

// File: tb/hreg_bank_bench.sv
module hreg_bank_bench;
  localparam int DW = 8;
  localparam int WR = 15;
  localparam int RD = 23;
  localparam int CN = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst = 1'b1;
  logic            host_mode = 1'b0;
  logic            host_cs_n = 1'b1;
  logic            host_rw = 1'b1;
  logic            host_ad = 1'b0;
  logic [DW-1:0]   bus_in = '0;
  logic [DW-1:0]   bus_out;
  logic            bus_oe;
  logic [CN-1:0]   ctrl_pin = 7'b1100000;
  logic            clip_trs_pin = 1'b0;
  logic [RD*DW-1:0] stat_in = '0;
  logic [WR*DW-1:0] cfg_out;
  logic [CN-1:0]   ctrl_en;

  hreg_bank u_hreg_bank (
    .clk(clk), .rst(rst), .host_mode(host_mode), .host_cs_n(host_cs_n),
    .host_rw(host_rw), .host_ad(host_ad), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .ctrl_pin(ctrl_pin), .clip_trs_pin(clip_trs_pin),
    .stat_in(stat_in), .cfg_out(cfg_out), .ctrl_en(ctrl_en)
  );

  logic [DW-1:0] wt_m [WR];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model_cfg();
    logic [127:0] r = '0;
    for (int i = 0; i < WR; i++) r[i*DW +: DW] = wt_m[i];
    return r;
  endfunction

  function automatic logic [CN-1:0] exp_en(input logic [7:0] b0, input logic [CN-1:0] p, input logic g);
    logic [CN-1:0] r;
    r[3:0] = b0[3:0] | p[3:0];
    r[4]   = b0[4] | p[4];
    r[6:5] = b0[6:5] & p[6:5];
    if (g) r[2:0] = 3'b111;
    return r;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    host_cs_n = 1'b0; host_ad = 1'b0; host_rw = 1'b1; bus_in = addr;
    @(negedge clk);
    host_ad = 1'b1; host_rw = 1'b0; bus_in = data;
    @(negedge clk);
    host_cs_n = 1'b1; host_ad = 1'b0; host_rw = 1'b1; bus_in = '0;
    if (!host_mode && addr < WR) wt_m[addr] = data;
  endtask

  task automatic do_read(input logic [7:0] addr, output logic [7:0] data, output logic oe);
    @(negedge clk);
    host_cs_n = 1'b0; host_ad = 1'b0; host_rw = 1'b1; bus_in = addr;
    @(negedge clk);
    host_ad = 1'b1;
    @(negedge clk);
    data = bus_out; oe = bus_oe;
    host_cs_n = 1'b1; host_ad = 1'b0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] addr);
    if (addr < RD) return stat_in[addr*DW +: DW];
    return 8'h00;
  endfunction

  task automatic check_en(input string tag);
    @(negedge clk);
    chk(tag, ctrl_en, exp_en(wt_m[0], ctrl_pin, clip_trs_pin));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WR; i++) wt_m[i] = '0;
    wt_m[0] = 8'h70;
    for (int i = 0; i < RD; i++) stat_in[i*DW +: DW] = 8'($urandom);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset table", cfg_out, model_cfg());
    chk("R1 reset bus_oe", bus_oe, 0);
    chk("R1 reset enables", ctrl_en, 7'b1110000);

    // Idle host: defaults hold, bus floats
    repeat (5) @(negedge clk);
    chk("R5 idle bus_oe", bus_oe, 0);
    chk("R1 idle table", cfg_out, model_cfg());

    // Checksum bit: pin ignored while bit is 1, effective after clearing
    ctrl_pin[4] = 1'b0;
    check_en("R9 cksum default");
    chk("R9 cksum still on", ctrl_en[4], 1);
    do_write(8'h00, 8'h60);
    chk("R2 write ctrl byte", cfg_out, model_cfg());
    check_en("R9 cksum cleared");
    chk("R9 cksum off", ctrl_en[4], 0);
    ctrl_pin[4] = 1'b1;
    check_en("R9 cksum via pin");
    chk("R11 pin seen next cycle", ctrl_en[4], 1);

    // Blanking pair: AND with pins
    ctrl_pin[6:5] = 2'b01;
    check_en("R8 and rule");
    chk("R8 blank enable off", ctrl_en[6], 0);
    chk("R8 vblank on", ctrl_en[5], 1);

    // Global pin forces three enables despite host zeros
    do_write(8'h00, 8'h00);
    ctrl_pin[2:0] = 3'b000;
    clip_trs_pin = 1'b1;
    check_en("R10 global force");
    chk("R10 forced bits", ctrl_en[2:0], 3'b111);
    clip_trs_pin = 1'b0;
    check_en("R7 release global");
    chk("R7 all off", ctrl_en[3:0], 4'b0000);

    // Out of range
    do_write(8'd15, 8'hA5);
    chk("R4 write past end", cfg_out, model_cfg());
    do_write(8'hFF, 8'h5A);
    chk("R4 write far", cfg_out, model_cfg());
    do_read(8'd23, rd, oe);
    chk("R4 read past end", rd, 8'h00);
    do_read(8'd22, rd, oe);
    chk("R3 read last", rd, exp_rd(8'd22));
    chk("R3 oe", oe, 1);
    @(negedge clk);
    chk("R5 oe drops", bus_oe, 0);

    // Serial mode: port disabled
    host_mode = 1'b1;
    do_write(8'd3, 8'hAB);
    @(negedge clk);
    chk("R6 no write", cfg_out, model_cfg());
    do_read(8'd3, rd, oe);
    chk("R6 no drive", oe, 0);
    host_mode = 1'b0;
    do_read(8'd3, rd, oe);
    chk("R6 address not latched in mode", rd, exp_rd(8'd3));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [7:0] a = 8'($urandom_range(0, 31));
        do_write(a, 8'($urandom));
        chk(a < WR ? "R2 random write" : "R4 random write", cfg_out, model_cfg());
        check_en("R7 R8 R9 after write");
      end else if (op == 1) begin
        logic [7:0] a = 8'($urandom_range(0, 31));
        do_read(a, rd, oe);
        chk(a < RD ? "R3 random read" : "R4 random read", rd, exp_rd(a));
        chk("R3 random oe", oe, 1);
        @(negedge clk);
        chk("R5 random float", bus_oe, 0);
      end else if (op == 2) begin
        @(negedge clk);
        ctrl_pin = 7'($urandom);
        clip_trs_pin = ($urandom_range(0, 3) == 0);
        check_en("R10 R11 pin change");
      end else begin
        @(negedge clk);
        for (int i = 0; i < RD; i++) stat_in[i*DW +: DW] = 8'($urandom);
        @(negedge clk);
      end
    end

    summary();
  end
endmodule